// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This block is a watchdog that runs down in two stages. Software enables it and must keep pinging it while the first stage is running. If the first stage runs out, a warning interrupt is raised and a second stage starts. The second stage ignores pings and cannot be stopped. It only gives software time to log or clean up before the reset. When the second stage runs out, a final interrupt is raised and, in the same cycle, a one-cycle reset request appears on one of three outputs. A mode field picks the whole chip, the CPU complex, or the execution pointer alone.

Time is counted in ticks of a single-cycle `tick` input, so any prescaler sits outside the block. The state machine has four states:
- IDLE: the counter follows the first-stage length.
- STAGE1: the countdown can be pinged.
- STAGE2: the countdown cannot be pinged and the control register is locked.
- FIRE: a single cycle that carries the reset pulse.

The transitions are:
- IDLE→STAGE1 when enable is set.
- STAGE1→IDLE when enable is cleared.
- STAGE1→STAGE1 with a reload on a ping.
- STAGE1→STAGE2 on the tick that takes the count past one.
- STAGE2→FIRE on the last tick of the second stage.
- FIRE→IDLE on the next cycle.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, the outputs and both interrupt flags are low, and the status phase reads idle. CTRL reads 0x2, which is enable 0 with mode CPU. Both length registers read all ones.
- R2: Register map (word addresses): 0 CTRL (bit0 enable, bits 2:1 mode), 1 LEN1, 2 LEN2, 3 PING (any write), 4 IRQ, 5 STATUS. Once enabled and one cycle has passed in IDLE, the block stays in STAGE1 for exactly LEN1 ticks. A length of 0 counts as 1. After the last of those ticks it is in STAGE2 with the count at LEN2, and the warning flag (IRQ bit0) is set.
- R3: A PING write during STAGE1 reloads the count to LEN1, and the block stays in STAGE1.
- R4: A PING write during STAGE2 leaves the count and the phase unchanged.
- R5: STAGE2 lasts exactly LEN2 ticks. The final flag (IRQ bit1) is set in the same cycle as the reset pulse. The pulse lasts one cycle, and the block then passes through IDLE.
- R6: The mode selects the reset output: 0 → `rst_chip`, 1 → `rst_cpu`, 2 → `rst_ptr`, 3 → `rst_cpu`. At most one reset output is high at a time.
- R7: Writing CTRL with enable 0 during IDLE or STAGE1 clears both interrupt flags. The block returns to IDLE with the count reloaded to LEN1.
- R8: CTRL writes during STAGE2 are ignored. Enable and mode read back unchanged, and the block keeps counting to the reset.
- R9: Writing 1 to an IRQ bit clears that flag. Writing 0 to it leaves the flag unchanged.
- R10: STATUS bits 1:0 hold the phase code: 0 idle, 1 stage 1, 2 stage 2, 3 fire. Bits 31:16 hold the remaining count, which reads LEN1 while the block is idle.
- R11: The count changes only on a tick (or a reload). Without ticks it holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Single-cycle count enable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_warn | output | 1 | Sticky first-stage expiry flag |
| irq_final | output | 1 | Sticky second-stage expiry flag |
| rst_chip | output | 1 | Whole-chip reset request pulse |
| rst_cpu | output | 1 | CPU-complex reset request pulse |
| rst_ptr | output | 1 | Execution-pointer reset request pulse |

## Verification
The properties assume that `tick` and PING writes arrive as independent single-cycle events. They also assume that a ping and a tick in the same STAGE1 cycle resolve as a reload, and that the bus performs at most one write per cycle to a decoded address. The bench drives all inputs on the falling edge. It issues each tick or write as a one-cycle strobe, never overlaps a write with a tick, and waits one idle cycle after enabling, so every stage length can be counted exactly in ticks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PH1  = 2'd1,
        ST_PH2  = 2'd2,
        ST_FIRE = 2'd3
    } wd_state_t;

    localparam logic [1:0] MODE_CHIP = 2'd0;
    localparam logic [1:0] MODE_CPU  = 2'd1;
    localparam logic [1:0] MODE_PTR  = 2'd2;

    localparam int A_CTRL   = 0;
    localparam int A_LEN1   = 1;
    localparam int A_LEN2   = 2;
    localparam int A_PING   = 3;
    localparam int A_IRQ    = 4;
    localparam int A_STATUS = 5;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 16,
    parameter logic [CNT_W-1:0] RST_LEN = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              lock,
    input  logic              warn_set,
    input  logic              fire_set,
    input  logic [1:0]        phase,
    input  logic [CNT_W-1:0]  cnt,
    output logic              ctrl_en,
    output logic [1:0]        ctrl_mode,
    output logic [CNT_W-1:0]  len1,
    output logic [CNT_W-1:0]  len2,
    output logic              ping,
    output logic              irq_warn,
    output logic              irq_final
);
    localparam int CNT_LSB = DATA_W / 2;

    logic wr_ctrl, wr_len1, wr_len2, wr_irq, dis_clr;
    logic unused_wdata;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(A_CTRL)) && !lock;
    assign wr_len1 = bus_wr && (bus_addr == ADDR_W'(A_LEN1));
    assign wr_len2 = bus_wr && (bus_addr == ADDR_W'(A_LEN2));
    assign wr_irq  = bus_wr && (bus_addr == ADDR_W'(A_IRQ));
    assign ping    = bus_wr && (bus_addr == ADDR_W'(A_PING));
    assign dis_clr = wr_ctrl && !bus_wdata[0];
    assign unused_wdata = ^bus_wdata[DATA_W-1:CNT_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_en   <= 1'b0;
            ctrl_mode <= MODE_CPU;
            len1      <= RST_LEN;
            len2      <= RST_LEN;
            irq_warn  <= 1'b0;
            irq_final <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl_en   <= bus_wdata[0];
                ctrl_mode <= bus_wdata[2:1];
            end
            if (wr_len1) len1 <= bus_wdata[CNT_W-1:0];
            if (wr_len2) len2 <= bus_wdata[CNT_W-1:0];
            irq_warn  <= warn_set ||
                         (irq_warn && !(wr_irq && bus_wdata[0]) && !dis_clr);
            irq_final <= fire_set ||
                         (irq_final && !(wr_irq && bus_wdata[1]) && !dis_clr);
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(A_CTRL):   bus_rdata[2:0] = {ctrl_mode, ctrl_en};
            ADDR_W'(A_LEN1):   bus_rdata[CNT_W-1:0] = len1;
            ADDR_W'(A_LEN2):   bus_rdata[CNT_W-1:0] = len2;
            ADDR_W'(A_IRQ):    bus_rdata[1:0] = {irq_final, irq_warn};
            ADDR_W'(A_STATUS): begin
                bus_rdata[1:0] = phase;
                bus_rdata[CNT_LSB +: CNT_W] = cnt;
            end
            default:           bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             ping,
    input  logic [CNT_W-1:0] len1,
    input  logic [CNT_W-1:0] len2,
    output wd_state_t        st,
    output logic [CNT_W-1:0] cnt,
    output logic             warn_set,
    output logic             fire_set,
    output logic             lock,
    output logic             fire,
    output logic [1:0]       phase
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    wd_state_t        st_n;
    logic [CNT_W-1:0] cnt_n, len1_e, len2_e;

    assign len1_e = (len1 == '0) ? ONE : len1;
    assign len2_e = (len2 == '0) ? ONE : len2;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    always_comb begin
        st_n     = st;
        cnt_n    = cnt;
        warn_set = 1'b0;
        fire_set = 1'b0;
        unique case (st)
            ST_IDLE: begin
                cnt_n = len1_e;
                if (en) st_n = ST_PH1;
            end
            ST_PH1: begin
                if (!en) begin
                    st_n  = ST_IDLE;
                    cnt_n = len1_e;
                end else if (ping) begin
                    cnt_n = len1_e;
                end else if (tick) begin
                    if (cnt == ONE) begin
                        st_n     = ST_PH2;
                        cnt_n    = len2_e;
                        warn_set = 1'b1;
                    end else begin
                        cnt_n = cnt - ONE;
                    end
                end
            end
            ST_PH2: begin
                if (tick) begin
                    if (cnt == ONE) begin
                        st_n     = ST_FIRE;
                        fire_set = 1'b1;
                    end else begin
                        cnt_n = cnt - ONE;
                    end
                end
            end
            ST_FIRE: begin
                st_n  = ST_IDLE;
                cnt_n = len1_e;
            end
        endcase
    end

    always_comb begin
        phase = st;
        lock  = (st == ST_PH2) || (st == ST_FIRE);
        fire  = (st == ST_FIRE);
    end
endmodule

// File: rtl/wdog_rst_steer.sv
module wdog_rst_steer
    import wdog_pkg::*;
(
    input  logic       fire,
    input  logic [1:0] mode,
    output logic       rst_chip,
    output logic       rst_cpu,
    output logic       rst_ptr
);
    always_comb begin
        rst_chip = 1'b0;
        rst_cpu  = 1'b0;
        rst_ptr  = 1'b0;
        unique case (mode)
            MODE_CHIP: rst_chip = fire;
            MODE_PTR:  rst_ptr  = fire;
            default:   rst_cpu  = fire;
        endcase
    end
endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdog_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 16,
    parameter logic [CNT_W-1:0] RST_LEN = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_warn,
    output logic              irq_final,
    output logic              rst_chip,
    output logic              rst_cpu,
    output logic              rst_ptr
);
    wd_state_t        st;
    logic [CNT_W-1:0] cnt, len1, len2;
    logic             ctrl_en, ping, lock, fire, warn_set, fire_set;
    logic [1:0]       ctrl_mode, phase;

    wdog_regs #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RST_LEN(RST_LEN)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lock(lock),
        .warn_set(warn_set), .fire_set(fire_set), .phase(phase), .cnt(cnt),
        .ctrl_en(ctrl_en), .ctrl_mode(ctrl_mode), .len1(len1), .len2(len2),
        .ping(ping), .irq_warn(irq_warn), .irq_final(irq_final)
    );

    wdog_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(ctrl_en), .ping(ping),
        .len1(len1), .len2(len2), .st(st), .cnt(cnt), .warn_set(warn_set),
        .fire_set(fire_set), .lock(lock), .fire(fire), .phase(phase)
    );

    wdog_rst_steer u_steer (
        .fire(fire), .mode(ctrl_mode),
        .rst_chip(rst_chip), .rst_cpu(rst_cpu), .rst_ptr(rst_ptr)
    );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
    import wdog_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             ping,
    input logic             en,
    input wd_state_t        st,
    input logic [CNT_W-1:0] cnt,
    input logic             irq_warn,
    input logic             irq_final,
    input logic             rst_chip,
    input logic             rst_cpu,
    input logic             rst_ptr
);
    logic any_rst;
    assign any_rst = rst_chip || rst_cpu || rst_ptr;

    p_rst_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rst_chip, rst_cpu, rst_ptr}));

    p_rst_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        any_rst |=> !any_rst);

    p_final_with_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
        any_rst |-> irq_final);

    p_stage2_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PH2) |=> (st == ST_PH2 || st == ST_FIRE));

    p_stage1_expire_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PH1 && en && !ping && tick && cnt == CNT_W'(1))
        |=> (st == ST_PH2 && irq_warn));

    p_ping_keeps_stage1_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PH1 && en && ping) |=> (st == ST_PH1));

    p_hold_without_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_PH2 && !tick) |=> $stable(cnt));
endmodule

bind wdog_two_stage wdog_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ping(ping), .en(ctrl_en),
    .st(st), .cnt(cnt), .irq_warn(irq_warn), .irq_final(irq_final),
    .rst_chip(rst_chip), .rst_cpu(rst_cpu), .rst_ptr(rst_ptr)
);

// File: tb/wdog_two_stage_test.sv
`timescale 1ns/1ps
module wdog_two_stage_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_warn, irq_final, rst_chip, rst_cpu, rst_ptr;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    wdog_two_stage uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_warn(irq_warn), .irq_final(irq_final),
        .rst_chip(rst_chip), .rst_cpu(rst_cpu), .rst_ptr(rst_ptr)
    );

    // {mode[1:0], len1[7:0], len2[7:0], expected {chip,cpu,ptr}}
    localparam logic [20:0] VEC [4] = '{
        {2'd0, 8'd3, 8'd2, 3'b100},
        {2'd1, 8'd0, 8'd4, 3'b010},
        {2'd2, 8'd5, 8'd0, 3'b001},
        {2'd3, 8'd2, 8'd3, 3'b010}
    };

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    initial begin
        #800_000;
        errors++;
        $display("FAIL watchdog expired actual=0x0 expected=0x1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset state
        rd(3'd0, v); check(v == 32'h2, "R1 ctrl", v, 32'h2);
        rd(3'd1, v); check(v == 32'hFFFF, "R1 len1", v, 32'hFFFF);
        rd(3'd4, v); check(v == 32'h0, "R1 irq", v, 32'h0);
        check({rst_chip, rst_cpu, rst_ptr} == 3'b000, "R1 rst outs",
              {rst_chip, rst_cpu, rst_ptr}, 0);
        // R10 idle status shows LEN1
        rd(3'd5, v); check(v == 32'hFFFF0000, "R10 idle status", v, 32'hFFFF0000);

        // Table loop: R2 stage lengths, R5 fire, R6 steering
        for (int k = 0; k < 4; k++) begin
            logic [1:0] m;
            logic [7:0] l1, l2;
            logic [2:0] ex;
            int e1, e2;
            {m, l1, l2, ex} = VEC[k];
            e1 = (l1 == 0) ? 1 : int'(l1);
            e2 = (l2 == 0) ? 1 : int'(l2);
            wr(3'd1, {24'd0, l1});
            wr(3'd2, {24'd0, l2});
            wr(3'd0, {29'd0, m, 1'b1});
            @(negedge clk);
            for (int i = 1; i <= e1; i++) begin
                pulse_tick();
                check(irq_warn == (i == e1), "R2 warn timing", irq_warn, (i == e1));
            end
            rd(3'd5, v);
            check(v == {16'(e2), 16'h2}, "R2 stage2 entry", v, {16'(e2), 16'h2});
            for (int j = 1; j <= e2; j++) begin
                pulse_tick();
                if (j < e2)
                    check({rst_chip, rst_cpu, rst_ptr} == 3'b000, "R5 early rst",
                          {rst_chip, rst_cpu, rst_ptr}, 0);
            end
            check({rst_chip, rst_cpu, rst_ptr} == ex, "R6 reset target",
                  {rst_chip, rst_cpu, rst_ptr}, ex);
            check(irq_final == 1'b1, "R5 final with reset", irq_final, 1);
            @(negedge clk);
            check({rst_chip, rst_cpu, rst_ptr} == 3'b000, "R5 one-cycle pulse",
                  {rst_chip, rst_cpu, rst_ptr}, 0);
            wr(3'd0, 32'h0);
        end

        // R3 ping in stage 1
        wr(3'd1, 32'd4);
        wr(3'd2, 32'd3);
        wr(3'd0, 32'h5);
        @(negedge clk);
        pulse_tick(); pulse_tick();
        rd(3'd5, v); check(v == 32'h00020001, "R3 before ping", v, 32'h00020001);
        wr(3'd3, 32'h0);
        rd(3'd5, v); check(v == 32'h00040001, "R3 ping reload", v, 32'h00040001);
        pulse_tick(); pulse_tick(); pulse_tick();
        check(irq_warn == 1'b0, "R3 still stage1", irq_warn, 0);
        pulse_tick();
        rd(3'd5, v); check(v == 32'h00030002, "R2 stage2 after ping", v, 32'h00030002);

        // R9 write-one-to-clear
        wr(3'd4, 32'h0);
        check(irq_warn == 1'b1, "R9 zero keeps flag", irq_warn, 1);
        wr(3'd4, 32'h1);
        check(irq_warn == 1'b0, "R9 one clears flag", irq_warn, 0);

        // R4 ping in stage 2
        pulse_tick();
        wr(3'd3, 32'h0);
        rd(3'd5, v); check(v == 32'h00020002, "R4 ping ignored", v, 32'h00020002);

        // R8 control locked
        wr(3'd0, 32'h0);
        rd(3'd0, v); check(v == 32'h5, "R8 ctrl locked", v, 32'h5);
        rd(3'd5, v); check(v[1:0] == 2'd2, "R8 still stage2", v, 32'h2);

        // R11 count holds without ticks
        repeat (6) @(negedge clk);
        rd(3'd5, v); check(v == 32'h00020002, "R11 hold", v, 32'h00020002);

        pulse_tick(); pulse_tick();
        check(rst_ptr == 1'b1, "R5 fire after ping", rst_ptr, 1);
        rd(3'd5, v); check(v[1:0] == 2'd3, "R10 fire phase", v, 32'h3);

        // R7 disable clears flags (block restarted since enable stayed set)
        repeat (2) @(negedge clk);
        rd(3'd5, v); check(v[1:0] == 2'd1, "R7 restarted", v, 32'h1);
        wr(3'd4, 32'h0);
        wr(3'd1, 32'h0);
        wr(3'd1, 32'd4);
        pulse_tick();
        rd(3'd4, v); check(v == 32'h2, "R7 flags before disable", v, 32'h2);
        wr(3'd0, 32'h0);
        rd(3'd4, v); check(v == 32'h0, "R7 flags cleared", v, 32'h0);
        @(negedge clk);
        rd(3'd5, v); check(v == 32'h00040000, "R7 idle reload", v, 32'h00040000);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule